// File: doc/BRIEF.md
# Two-Group Thread Issue Picker

This block decides, every clock cycle, which hardware thread of a core may issue into each integer execution unit. The core's threads are split into groups, two groups of four by default. Each group owns one integer unit that accepts a single instruction per cycle. The picker therefore names at most one thread per group per cycle, and so up to two threads in total. It sits between the fetch stage and the decode stage.

Each thread brings two flags. One says it has an instruction ready. The other says it is parked on a long-latency event such as a load miss. A thread may be picked only when it is ready and not parked. Inside a group the picker favours the eligible thread that was picked least recently. It may move to a different thread on every cycle, and a switch costs nothing. The grant follows the inputs of the same cycle with no register delay. Only the recency ordering is stored, and it is updated at the clock edge.

Top module: `thread_picker`

## Requirements
- R1: A thread is eligible exactly when its ready bit is 1 and its wait bit is 0. A thread whose wait bit is 1 is never granted, even when its ready bit is 1.
- R2: Within each group at most one grant bit is 1 in any cycle.
- R3: A group's valid bit is 1 exactly when at least one of its threads is eligible. When none is eligible, the valid bit is 0 and the group's four grant bits are all 0.
- R4: Within a group, the grant goes to the eligible thread that was granted least recently. A thread granted in one cycle is not granted in the next cycle if any other thread of its group is eligible then.
- R5: Group g owns thread bits g*4 to g*4+3 of every vector, and valid bit g. One group's inputs never change another group's grant or ordering.
- R6: A thread that stays eligible is granted within at most four consecutive cycles.
- R7: Grants are combinational from the inputs of the same cycle. Reset sets each group's ordering so that a lower index counts as less recently granted, and reset applies this ordering even after earlier activity. With all threads eligible, the first grants after reset are therefore local thread 0 and then local thread 1.
- R8: A cycle in which a group grants nothing leaves that group's ordering unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the ordering state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the ordering state |
| thread_ready_i | input | 8 | Per-thread instruction-ready flags; bit g*4+k is thread k of group g |
| thread_wait_i | input | 8 | Per-thread long-latency wait flags, same bit layout |
| grant_o | output | 8 | Per-group one-hot grant, same bit layout |
| grant_valid_o | output | 2 | Bit g is high when group g grants a thread |

## Verification
The hardest case to reach from the ports is a recency ordering that is no longer plain rotation. It arises when threads drop in and out of eligibility, so that the oldest thread is one that has been skipped while parked and not simply the next index. The vector table drives a chosen sequence of ready and wait patterns to build such orderings. Among these are cycles with nothing eligible, which must leave the ordering frozen. Each later grant then exposes the whole ordering history. A long run keeps one thread eligible while its neighbours come and go, and checks that its wait never reaches four cycles.

// File: rtl/picker_pkg.sv
package picker_pkg;
   localparam int unsigned DEF_GROUPS = 2;
   localparam int unsigned DEF_TPG    = 4;

   // Width of a saturating per-thread starvation counter
   function automatic int unsigned starve_width(input int unsigned tpg);
      return $clog2(tpg) + 2;
   endfunction
endpackage

// File: rtl/pick_eligibility.sv
module pick_eligibility #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0] ready_i,
   input  logic [N-1:0] wait_i,
   output logic [N-1:0] elig_o
);
   // A parked thread is held out regardless of its ready flag
   always_comb begin
      elig_o = ready_i & ~wait_i;
   end
endmodule

// File: rtl/pick_lru_arbiter.sv
module pick_lru_arbiter #(
   parameter int unsigned TPG = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [TPG-1:0] elig_i,
   input  logic [TPG-1:0] wait_i,
   output logic [TPG-1:0] grant_o,
   output logic           valid_o
);
   import picker_pkg::*;
   localparam int unsigned CW = starve_width(TPG);

   // older_q[i][j] = 1 : thread i was granted less recently than thread j
   logic [TPG-1:0][TPG-1:0] older_q;
   logic [TPG-1:0]          win;

   if (TPG < 2) begin : g_bad_tpg
      $error("pick_lru_arbiter needs at least two threads per group");
   end

   always_comb begin
      for (int i = 0; i < TPG; i++) begin
         win[i] = elig_i[i];
         for (int j = 0; j < TPG; j++) begin
            if (j != i && elig_i[j] && !older_q[i][j]) win[i] = 1'b0;
         end
      end
   end

   assign grant_o = win;
   assign valid_o = |win;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < TPG; i++)
            for (int j = 0; j < TPG; j++)
               older_q[i][j] <= (i < j);
      end else if (|win) begin
         for (int i = 0; i < TPG; i++)
            for (int j = 0; j < TPG; j++) begin
               if (i != j && win[i]) older_q[i][j] <= 1'b0;
               if (i != j && win[j]) older_q[i][j] <= 1'b1;
            end
      end
   end

   // Starvation watch: cycles a thread has stayed eligible without a grant
   logic [TPG-1:0][CW-1:0] starve_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         starve_q <= '0;
      end else begin
         for (int i = 0; i < TPG; i++) begin
            if (!elig_i[i] || win[i])       starve_q[i] <= '0;
            else if (starve_q[i] != '1)     starve_q[i] <= starve_q[i] + 1'b1;
         end
      end
   end

   assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));
   assert_valid_tracks_elig_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o == (elig_i != '0));
   assert_idle_holds_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |=> $stable(older_q));

   for (genvar t = 0; t < TPG; t++) begin : g_thread_chk
      assert_parked_not_granted_R1: assert property (@(posedge clk) disable iff (!rst_n)
         wait_i[t] |-> !grant_o[t]);
      assert_recent_yields_R4: assert property (@(posedge clk) disable iff (!rst_n)
         grant_o[t] |=> !(grant_o[t] && ((elig_i & ~(TPG'(1) << t)) != '0)));
      assert_no_starve_R6: assert property (@(posedge clk) disable iff (!rst_n)
         int'(starve_q[t]) < int'(TPG));
   end
endmodule

// File: rtl/thread_picker.sv
module thread_picker #(
   parameter int unsigned GROUPS = picker_pkg::DEF_GROUPS,
   parameter int unsigned TPG    = picker_pkg::DEF_TPG
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [GROUPS*TPG-1:0] thread_ready_i,
   input  logic [GROUPS*TPG-1:0] thread_wait_i,
   output logic [GROUPS*TPG-1:0] grant_o,
   output logic [GROUPS-1:0]     grant_valid_o
);
   localparam int unsigned NT = GROUPS * TPG;

   if (GROUPS < 1) begin : g_bad_groups
      $error("thread_picker needs at least one group");
   end

   logic [NT-1:0] elig;

   pick_eligibility #(.N(NT)) u_elig (
      .ready_i (thread_ready_i),
      .wait_i  (thread_wait_i),
      .elig_o  (elig)
   );

   for (genvar g = 0; g < GROUPS; g++) begin : g_group
      pick_lru_arbiter #(.TPG(TPG)) u_arb (
         .clk     (clk),
         .rst_n   (rst_n),
         .elig_i  (elig[g*TPG +: TPG]),
         .wait_i  (thread_wait_i[g*TPG +: TPG]),
         .grant_o (grant_o[g*TPG +: TPG]),
         .valid_o (grant_valid_o[g])
      );
   end

   assert_group_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o & ~elig) == '0);
endmodule

// File: tb/thread_picker_bench.sv
module thread_picker_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ready = '0;
   logic [7:0] waitf = '0;
   logic [7:0] grant;
   logic [1:0] gvalid;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   thread_picker u_thread_picker (
      .clk            (clk),
      .rst_n          (rst_n),
      .thread_ready_i (ready),
      .thread_wait_i  (waitf),
      .grant_o        (grant),
      .grant_valid_o  (gvalid)
   );

   // {ready[25:18], wait[17:10], expected grant[9:2], expected valid[1:0]}
   localparam logic [25:0] VEC [8] = '{
      {8'hFF, 8'h00, 8'h11, 2'b11},   // R7 first pick is local 0 in both groups
      {8'h8F, 8'h00, 8'h82, 2'b11},   // R4 rotation; group1 only local 3
      {8'h0F, 8'h04, 8'h08, 2'b01},   // R1 parked local 2 skipped; R3 group1 idle
      {8'hFF, 8'hF0, 8'h04, 2'b01},   // R1 all group1 parked; R4 local 2 oldest
      {8'h50, 8'h00, 8'h40, 2'b10},   // R5 R8 group0 idle, group1 picks older local 2
      {8'hFC, 8'h00, 8'h28, 2'b11},   // R8 group0 order survived idle cycle
      {8'hFF, 8'h10, 8'h81, 2'b11},   // R4 group1 oldest eligible is local 3
      {8'hFA, 8'h00, 8'h12, 2'b11}    // R4 R5 history-dependent picks
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      int gap [8];
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R3 reset idle grant", grant, 8'h00);
      check("R3 reset idle valid", {6'b0, gvalid}, 8'h00);

      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         ready = VEC[k][25:18];
         waitf = VEC[k][17:10];
         #1;
         check($sformatf("R1/R2/R4 vector %0d grant", k), grant, VEC[k][9:2]);
         check($sformatf("R3 vector %0d valid", k), {6'b0, gvalid}, {6'b0, VEC[k][1:0]});
      end

      // R6: local thread 0 of group0 and all of group1 stay eligible
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int t = 0; t < 8; t++) gap[t] = 0;
      for (int c = 0; c < 24; c++) begin
         @(negedge clk);
         ready = {4'hF, 3'(c * 5 + 3), 1'b1};
         waitf = {4'h0, 3'(c * 3), 1'b0};
         #1;
         for (int t = 0; t < 8; t++) begin
            if (t == 0 || t >= 4) begin
               if (grant[t]) gap[t] = 0;
               else gap[t]++;
               check($sformatf("R6 thread %0d gap", t), 8'(gap[t] < 4), 8'h01);
            end
         end
      end

      // R7: reset restores ordering after activity
      @(negedge clk);
      ready = 8'hFF;
      waitf = 8'h00;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R7 first grant after reset", grant, 8'h11);
      @(negedge clk);
      #1;
      check("R7 second grant after reset", grant, 8'h22);

      // R1: ready but parked everywhere gives nothing
      @(negedge clk);
      waitf = 8'hFF;
      #1;
      check("R1 all parked grant", grant, 8'h00);
      check("R3 all parked valid", {6'b0, gvalid}, 8'h00);

      // R8 R5: idle cycle above kept order; group1 alone eligible
      @(negedge clk);
      waitf = 8'h0F;
      #1;
      check("R5 R8 group1 only", grant, 8'h40);

      finish_run();
   end
endmodule